// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block steps a receive DMA channel through a linked list of buffer descriptors held in memory. Software loads the address of the first descriptor into a pointer register while the channel is stopped, then issues a start command. From then on the walker runs without pausing. It fetches a descriptor through a request/response read port. It waits for the data path to report that the buffer is full, and then reports the completed buffer together with its frame-start and frame-end flags. It returns the descriptor to software by a write-back request that clears its ownership bit. Finally it follows the next-descriptor pointer to the next entry.

A fetched descriptor that software does not own, or one whose link pointer is zero, is treated as a fatal resource error. The channel stops at once and a sticky error flag is raised. The flag drives a maskable interrupt and is cleared by a write-one-to-clear pulse. An abort command stops the channel from any state. A restart needs a fresh pointer load, if one is wanted, and a new start command.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset the channel is stopped (`running`=0), no read or write-back request is raised, `buf_ready`, `buf_done`, `err_flag` and `irq` are 0, and `cur_ptr` is 0.
- R2: A `ptr_wr` pulse loads `ptr_wdata` into `cur_ptr` only while the channel is stopped. While it runs, `ptr_wr` is ignored and `cur_ptr` changes only when the walker advances along the chain.
- R3: A `start_cmd` pulse on a stopped channel raises `rd_req` with `rd_addr` = `cur_ptr`. The request and its address stay unchanged until `rd_ack`.
- R4: When `buf_full` arrives while `buf_ready` is high, `buf_done` pulses for one cycle. In that cycle `buf_addr` is the descriptor address, `buf_sof` is its first flag and `buf_eof` is its last flag.
- R5: After a buffer completes, `wb_req` is raised with `wb_addr` = the completed descriptor's address. This asks for its owner bit to be cleared. The request is held until `wb_ack`, and the walker then fetches the descriptor named by that entry's next pointer.
- R6: A fetched descriptor with owner bit 0 sets `err_flag`, stops the channel and never raises `buf_ready` for it.
- R7: A fetched descriptor with next pointer equal to 0 sets `err_flag` and stops the channel in the same way.
- R8: `irq` is high exactly when `err_flag` is set and `irq_mask` is 1. `err_flag` stays set until an `err_clr` pulse clears it.
- R9: An `abort_cmd` pulse stops the channel from any active state, drops pending requests and does not set `err_flag`. A later `start_cmd` restarts the walk at `cur_ptr`.
- R10: A descriptor with both first and last flags set is reported as a complete single-buffer frame (`buf_sof`=1 and `buf_eof`=1 on the same `buf_done`).
- R11: A `start_cmd` pulse while the channel runs has no effect on its state or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Write strobe for the current-descriptor pointer |
| ptr_wdata | input | AW | Pointer value to load |
| start_cmd | input | 1 | Start command pulse |
| abort_cmd | input | 1 | Abort command pulse |
| irq_mask | input | 1 | Interrupt enable for the resource error |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| running | output | 1 | Channel active |
| cur_ptr | output | AW | Current-descriptor pointer |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor read address |
| rd_ack | input | 1 | Read response valid |
| rd_owner | input | 1 | Owner bit of the fetched descriptor (1 = DMA) |
| rd_first | input | 1 | First-buffer flag of the fetched descriptor |
| rd_last | input | 1 | Last-buffer flag of the fetched descriptor |
| rd_next | input | AW | Next-descriptor pointer of the fetched descriptor |
| wb_req | output | 1 | Write-back request (clear owner bit) |
| wb_addr | output | AW | Descriptor address for write-back |
| wb_ack | input | 1 | Write-back done |
| buf_ready | output | 1 | Valid descriptor loaded, buffer open for data |
| buf_full | input | 1 | Data path reports the buffer is full |
| buf_done | output | 1 | One-cycle pulse: buffer handed off |
| buf_addr | output | AW | Descriptor address of the handed-off buffer |
| buf_sof | output | 1 | Handed-off buffer starts a frame |
| buf_eof | output | 1 | Handed-off buffer ends a frame |
| err_flag | output | 1 | Sticky receive resource-error flag |
| irq | output | 1 | Masked resource-error interrupt |

## Verification
Every cycle, the assertions check the local rules. Read and write-back requests must hold steady until acknowledged. A completed buffer must be followed by a write-back to its own address, and a write-back acknowledge by the next fetch. The pointer must stay frozen while the channel runs. A rising error must leave the channel stopped, and the error flag may only fall after a clear pulse. Other behaviour can only be shown by the bench's scenarios. These are the order and flags of handed-off buffers along a multi-descriptor chain, and the owner bits actually cleared in the memory model. They also cover the two distinct abort causes, the effect of the interrupt mask, and restart after a software abort.

// File: rtl/rx_desc_walker.sv
`timescale 1ns/1ps
module rx_desc_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          start_cmd,
  input  logic          abort_cmd,
  input  logic          irq_mask,
  input  logic          err_clr,
  output logic          running,
  output logic [AW-1:0] cur_ptr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_owner,
  input  logic          rd_first,
  input  logic          rd_last,
  input  logic [AW-1:0] rd_next,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_ack,
  output logic          buf_ready,
  input  logic          buf_full,
  output logic          buf_done,
  output logic [AW-1:0] buf_addr,
  output logic          buf_sof,
  output logic          buf_eof,
  output logic          err_flag,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FILL, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] nxt_q;
  logic          sof_q, eof_q;
  logic          bad_desc;

  assign bad_desc  = !rd_owner || (rd_next == '0);
  assign running   = (st != S_IDLE);
  assign rd_req    = (st == S_FETCH);
  assign rd_addr   = cur_ptr;
  assign wb_req    = (st == S_WB);
  assign wb_addr   = cur_ptr;
  assign buf_ready = (st == S_FILL);
  assign irq       = err_flag & irq_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_ptr  <= '0;
      nxt_q    <= '0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      buf_done <= 1'b0;
      buf_addr <= '0;
      buf_sof  <= 1'b0;
      buf_eof  <= 1'b0;
    end else begin
      buf_done <= 1'b0;
      if (abort_cmd) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (ptr_wr) cur_ptr <= ptr_wdata;
            if (start_cmd) st <= S_FETCH;
          end
          S_FETCH: begin
            if (rd_ack) begin
              if (bad_desc) begin
                st <= S_IDLE;
              end else begin
                st    <= S_FILL;
                nxt_q <= rd_next;
                sof_q <= rd_first;
                eof_q <= rd_last;
              end
            end
          end
          S_FILL: begin
            if (buf_full) begin
              buf_done <= 1'b1;
              buf_addr <= cur_ptr;
              buf_sof  <= sof_q;
              buf_eof  <= eof_q;
              st       <= S_WB;
            end
          end
          S_WB: begin
            if (wb_ack) begin
              cur_ptr <= nxt_q;
              st      <= S_FETCH;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      err_flag <= 1'b0;
    else if (st == S_FETCH && rd_ack && bad_desc && !abort_cmd)
      err_flag <= 1'b1;
    else if (err_clr)
      err_flag <= 1'b0;
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !abort_cmd) |=> (rd_req && $stable(rd_addr)));

  // R5
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack && !abort_cmd) |=> (wb_req && $stable(wb_addr)));

  // R4
  done_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> (wb_req && wb_addr == buf_addr));

  // R5
  wb_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack && !abort_cmd) |=> rd_req);

  // R2
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wb_ack) |=> $stable(cur_ptr));

  // R6
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (!running && !buf_ready));

  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(err_clr));

endmodule

// File: tb/rx_desc_walker_test.sv
`timescale 1ns/1ps
module rx_desc_walker_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ptr_wr = 0, start_cmd = 0, abort_cmd = 0, irq_mask = 0, err_clr = 0;
  logic [AW-1:0] ptr_wdata = '0;
  logic running, rd_req, wb_req, buf_ready, buf_done, buf_sof, buf_eof, err_flag, irq;
  logic [AW-1:0] cur_ptr, rd_addr, wb_addr, buf_addr;
  logic rd_ack = 0, rd_owner = 0, rd_first = 0, rd_last = 0, wb_ack = 0, buf_full = 0;
  logic [AW-1:0] rd_next = '0;

  rx_desc_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .start_cmd(start_cmd), .abort_cmd(abort_cmd), .irq_mask(irq_mask), .err_clr(err_clr),
    .running(running), .cur_ptr(cur_ptr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_owner(rd_owner), .rd_first(rd_first), .rd_last(rd_last),
    .rd_next(rd_next), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .buf_ready(buf_ready), .buf_full(buf_full), .buf_done(buf_done),
    .buf_addr(buf_addr), .buf_sof(buf_sof), .buf_eof(buf_eof),
    .err_flag(err_flag), .irq(irq));

  always #10 clk = ~clk;

  logic          m_own [16];
  logic          m_fst [16];
  logic          m_lst [16];
  logic [AW-1:0] m_nxt [16];

  always @(posedge clk) begin
    rd_ack <= 1'b0;
    wb_ack <= 1'b0;
    if (rd_req && !rd_ack) begin
      rd_ack   <= 1'b1;
      rd_owner <= m_own[rd_addr[7:4]];
      rd_first <= m_fst[rd_addr[7:4]];
      rd_last  <= m_lst[rd_addr[7:4]];
      rd_next  <= m_nxt[rd_addr[7:4]];
    end
    if (wb_req && !wb_ack) begin
      wb_ack <= 1'b1;
      m_own[wb_addr[7:4]] <= 1'b0;
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [AW+1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && buf_done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected buf_done", {buf_sof, buf_eof, buf_addr}, 0);
      end else begin
        logic [AW+1:0] e;
        e = exp_q.pop_front();
        chk({buf_sof, buf_eof, buf_addr} == e, "R4/R10 handed-off buffer",
            {buf_sof, buf_eof, buf_addr}, e);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse(ref logic s); s = 1'b1; tick(); s = 1'b0; endtask

  task automatic set_desc(input int a, input bit own, input bit f, input bit l, input int nx);
    m_own[a[7:4]] = own; m_fst[a[7:4]] = f; m_lst[a[7:4]] = l; m_nxt[a[7:4]] = nx;
  endtask

  task automatic wait_ready(output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (buf_ready) begin got = 1; break; end
      tick();
    end
  endtask

  task automatic fill(input int a, input bit f, input bit l, input string tag);
    bit got;
    wait_ready(got);
    chk(got, {tag, " buf_ready"}, got, 1);
    if (got) begin
      exp_q.push_back({f, l, AW'(a)});
      pulse(buf_full);
    end
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 40; i++) begin
      if (!running) break;
      tick();
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) set_desc(i * 16, 0, 0, 0, 0);
    tick(); tick();
    // R1
    chk(!running && !rd_req && !wb_req && !buf_ready, "R1 idle after reset",
        {running, rd_req, wb_req, buf_ready}, 0);
    chk(!err_flag && !irq && !buf_done && cur_ptr == 0, "R1 flags and pointer",
        {err_flag, irq, buf_done}, 0);
    rst_n = 1'b1;
    tick();

    set_desc('h10, 1, 1, 0, 'h20);
    set_desc('h20, 1, 0, 0, 'h30);
    set_desc('h30, 1, 0, 1, 'h40);
    set_desc('h40, 1, 1, 1, 'h50);
    set_desc('h50, 0, 1, 1, 'h60);
    ptr_wdata = 'h10;
    pulse(ptr_wr);
    // R2
    chk(cur_ptr == 'h10, "R2 pointer load while stopped", cur_ptr, 'h10);
    irq_mask = 1'b1;
    start_cmd = 1'b1; tick(); start_cmd = 1'b0;
    // R3
    chk(rd_req && rd_addr == 'h10, "R3 first fetch address", rd_addr, 'h10);
    begin
      bit got;
      wait_ready(got);
      ptr_wdata = 'hA0;
      pulse(ptr_wr);
      // R2
      chk(cur_ptr == 'h10, "R2 pointer write ignored while running", cur_ptr, 'h10);
      pulse(start_cmd);
      // R11
      chk(buf_ready && cur_ptr == 'h10, "R11 start ignored while running",
          {buf_ready, cur_ptr}, {1'b1, 32'h10});
    end
    fill('h10, 1, 0, "R4 desc 0x10");
    fill('h20, 0, 0, "R5 desc 0x20");
    fill('h30, 0, 1, "R4 desc 0x30");
    fill('h40, 1, 1, "R10 desc 0x40");
    wait_stop();
    // R6
    chk(!running && err_flag, "R6 owner=0 aborts", {running, err_flag}, 2'b01);
    chk(cur_ptr == 'h50, "R6 stopped on bad descriptor", cur_ptr, 'h50);
    // R8
    chk(irq == 1'b1, "R8 irq with mask set", irq, 1);
    // R5
    chk(!m_own['h1] && !m_own['h2] && !m_own['h3] && !m_own['h4], "R5 owner bits cleared",
        {m_own['h1], m_own['h2], m_own['h3], m_own['h4]}, 0);
    chk(exp_q.size() == 0, "R4 all buffers handed off", exp_q.size(), 0);

    irq_mask = 1'b0; tick();
    // R8
    chk(err_flag && !irq, "R8 mask blocks irq", {err_flag, irq}, 2'b10);
    tick(); tick();
    chk(err_flag, "R8 flag sticky", err_flag, 1);
    pulse(err_clr);
    chk(!err_flag, "R8 clear pulse", err_flag, 0);

    set_desc('h60, 1, 1, 1, 'h0);
    ptr_wdata = 'h60;
    pulse(ptr_wr);
    irq_mask = 1'b1;
    pulse(start_cmd);
    wait_stop();
    // R7
    chk(!running && err_flag && irq, "R7 null next aborts", {running, err_flag, irq}, 3'b011);
    chk(!buf_ready && m_own['h6], "R7 no buffer opened", {buf_ready, m_own['h6]}, 2'b01);
    pulse(err_clr);

    set_desc('h70, 1, 1, 1, 'h80);
    set_desc('h80, 0, 0, 0, 'h90);
    ptr_wdata = 'h70;
    pulse(ptr_wr);
    pulse(start_cmd);
    begin
      bit got;
      wait_ready(got);
      pulse(abort_cmd);
      tick();
      // R9
      chk(!running && !rd_req && !wb_req && !err_flag, "R9 abort stops cleanly",
          {running, rd_req, wb_req, err_flag}, 0);
    end
    pulse(start_cmd);
    // R9
    chk(rd_req && rd_addr == 'h70, "R9 restart at pointer", rd_addr, 'h70);
    fill('h70, 1, 1, "R9 restart buffer");
    wait_stop();
    tick();
    chk(exp_q.size() == 0 && err_flag, "R9 restart completed then hit owner error",
        {exp_q.size(), err_flag}, 1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule